// File: doc/BRIEF.md
# Bounds Table Store Walker

This unit performs the memory side of storing one lower/upper bounds pair into a two-level bounds table. On a start pulse it registers every operand, then forms the address of a directory entry from the base address and the directory base held in a configuration word. It reads that entry over a single-outstanding memory port and inspects its valid bit. When the entry is valid, the unit derives the table-entry address from the base address and the entry contents. It then writes three words: lower bound, upper bound and the unscaled pointer value.

Two address widths are supported. The narrow mode works on 32-bit quantities, zero-extended onto the 64-bit bus. The wide mode works on 64-bit quantities. In wide mode the number of base-address bits that select the directory entry grows with a 5-bit user width adjustment, but only at privilege level 3. An invalid directory entry ends the walk with a one-cycle fault pulse and no writes. In that case a status word is loaded with the directory-entry address with bit 1 set.

Top module: `bts_walker`

## Requirements
- R1: After reset the unit is idle (`busyOut` 0), issues no memory request, raises neither pulse, and `statusOut` is zero.
- R2: In narrow mode (`wideIn`=0) the directory-entry read address is the 32-bit sum of ({base[31:12], 2'b00}) and ({cfg[31:12], 12'h000}), zero-extended to 64 bits.
- R3: In wide mode the directory-entry read address is (base bits 20 up to 47+W, shifted right by 17 with bits below 3 cleared) plus ({cfg[63:12], 12'h000}). W is 0 when `privIn` is 0, 1 or 2, and equals `userWidthIn` when `privIn` is 3. Bits above 63 do not exist.
- R4: A directory entry read with bit 0 equal to 0 produces a one-cycle `faultOut` pulse and no write. From that pulse onward `statusOut` holds the directory-entry address ORed with 64'h2. A valid entry never produces a fault.
- R5: In narrow mode the table-entry address is the 32-bit sum of ({base[11:2], 4'h0}) and ({dir[31:2], 2'b00}). The three writes go to that address plus 0, 4 and 8, with address and data bits 63:32 driven to zero. Directory bits 63:32 are ignored.
- R6: In wide mode the table-entry address is ({base[19:3], 5'h00}) plus ({dir[63:3], 3'b000}). The three writes go to that address plus 0, 8 and 16.
- R7: The writes come in the order lower bound, upper bound, pointer, and the pointer word is `ptrIn` unchanged.
- R8: After the third write is granted, `doneOut` is high for exactly one cycle, then `busyOut` is low.
- R9: All operands are taken on the start cycle. A start pulse or operand change while busy, including the cycle of a done pulse, has no effect.
- R10: Only one access is in flight. A request holds its address and direction until granted, and no request is raised while read data is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start pulse, taken only when idle |
| wideIn | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| baseIn | input | 64 | Base address, displacement already added |
| ptrIn | input | 64 | Pointer value stored in the third word |
| lowerIn | input | 64 | Lower bound |
| upperIn | input | 64 | Upper bound |
| cfgIn | input | 64 | Configuration word, directory base in bits 63:12 |
| privIn | input | 2 | Privilege level |
| userWidthIn | input | 5 | User address-width adjustment |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 64 | Byte address |
| memWdata | output | 64 | Write data |
| memGnt | input | 1 | Request accepted this cycle |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 64 | Read data |
| busyOut | output | 1 | Walk in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| faultOut | output | 1 | One-cycle invalid-entry pulse |
| statusOut | output | 64 | Fault status word |

## Verification
The completion pulse and a fresh start request can meet in one cycle. The bench raises `startIn` with new operands on the exact cycle `doneOut` is seen, and drops it one cycle later. It then judges that `busyOut` and `memReq` stay low, which shows the start was dropped rather than queued. Grants and read data also coincide with busy-time start pulses and operand changes on every walk. The scoreboard judges these cases by comparing each granted address and word against values derived only from the captured operands.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int BUS_W    = 64;
  localparam int NARROW_W = 32;
  localparam int PAGE_LSB = 12;
  localparam int DIR_LSB  = 20;
  localparam int VA_TOP   = 47;
  localparam int UW_W     = 5;
  localparam int PRIV_W   = 2;
  localparam int SEL_W    = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_DIR, S_WAIT_DIR, S_WRITE_LO,
    S_WRITE_HI, S_WRITE_PTR, S_DONE, S_FAULT
  } walkState_t;

  typedef struct packed {
    logic             capture;
    logic             latchDir;
    logic             loadStatus;
    logic             rdPhase;
    logic             wrPhase;
    logic [SEL_W-1:0] wordSel;
  } walkStrobes_t;
endpackage

// File: rtl/bts_ctrl.sv
module bts_ctrl
  import bts_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         memGnt,
  input  logic         memRvalid,
  input  logic         dirValidBit,
  output walkStrobes_t strobes,
  output logic         memReq,
  output logic         memWe,
  output logic         busyOut,
  output logic         doneOut,
  output logic         faultOut
);
  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:      if (startIn)   nextState = S_READ_DIR;
      S_READ_DIR:  if (memGnt)    nextState = S_WAIT_DIR;
      S_WAIT_DIR:  if (memRvalid) nextState = dirValidBit ? S_WRITE_LO : S_FAULT;
      S_WRITE_LO:  if (memGnt)    nextState = S_WRITE_HI;
      S_WRITE_HI:  if (memGnt)    nextState = S_WRITE_PTR;
      S_WRITE_PTR: if (memGnt)    nextState = S_DONE;
      S_DONE:                     nextState = S_IDLE;
      S_FAULT:                    nextState = S_IDLE;
      default:                    nextState = S_IDLE;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.capture    = (state == S_IDLE) && startIn;
    strobes.latchDir   = (state == S_WAIT_DIR) && memRvalid && dirValidBit;
    strobes.loadStatus = (state == S_WAIT_DIR) && memRvalid && !dirValidBit;
    strobes.rdPhase    = (state == S_READ_DIR);
    strobes.wrPhase    = (state == S_WRITE_LO) || (state == S_WRITE_HI) ||
                         (state == S_WRITE_PTR);
    strobes.wordSel    = (state == S_WRITE_HI)  ? SEL_W'(1) :
                         (state == S_WRITE_PTR) ? SEL_W'(2) : SEL_W'(0);
  end

  assign memReq   = strobes.rdPhase || strobes.wrPhase;
  assign memWe    = strobes.wrPhase;
  assign busyOut  = (state != S_IDLE);
  assign doneOut  = (state == S_DONE);
  assign faultOut = (state == S_FAULT);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq);
  assert_no_req_waiting_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_DIR) |-> !memReq);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> (!doneOut && !busyOut));
  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && faultOut));
  assert_start_on_done_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && startIn) |=> (state == S_IDLE));
  assert_fault_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |=> !memReq);
endmodule

// File: rtl/bts_datapath.sv
module bts_datapath
  import bts_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strobes,
  input  logic               wideIn,
  input  logic [BUS_W-1:0]   baseIn,
  input  logic [BUS_W-1:0]   ptrIn,
  input  logic [BUS_W-1:0]   lowerIn,
  input  logic [BUS_W-1:0]   upperIn,
  input  logic [BUS_W-1:0]   cfgIn,
  input  logic [PRIV_W-1:0]  privIn,
  input  logic [UW_W-1:0]    userWidthIn,
  input  logic [BUS_W-1:0]   memRdata,
  output logic               dirValidBit,
  output logic [BUS_W-1:0]   memAddr,
  output logic [BUS_W-1:0]   memWdata,
  output logic [BUS_W-1:0]   statusOut
);
  localparam int TOP_W = $clog2(BUS_W) + 1;
  localparam logic [PRIV_W-1:0] USER_PRIV = '1;

  logic                    wideQ;
  logic [BUS_W-1:2]        baseQ;
  logic [BUS_W-1:0]        ptrQ, lowQ, highQ;
  logic [BUS_W-1:PAGE_LSB] cfgQ;
  logic [UW_W-1:0]         mawaQ;
  logic [BUS_W-1:2]        dirQ;
  logic [BUS_W-1:0]        statusQ;
  logic [1:0]              unusedRdBits;

  assign unusedRdBits = memRdata[1:0];
  assign dirValidBit  = memRdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideQ <= 1'b0; baseQ <= '0; ptrQ <= '0; lowQ <= '0; highQ <= '0;
      cfgQ  <= '0;   mawaQ <= '0;
    end else if (strobes.capture) begin
      wideQ <= wideIn;
      baseQ <= baseIn[BUS_W-1:2];
      ptrQ  <= ptrIn;
      lowQ  <= lowerIn;
      highQ <= upperIn;
      cfgQ  <= cfgIn[BUS_W-1:PAGE_LSB];
      mawaQ <= (privIn == USER_PRIV) ? userWidthIn : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirQ <= '0;
    else if (strobes.latchDir)
      dirQ <= wideQ ? memRdata[BUS_W-1:2]
                    : {{(BUS_W-NARROW_W){1'b0}}, memRdata[NARROW_W-1:2]};
  end

  // Directory-entry address, both widths
  logic [TOP_W-1:0]    topBit;
  logic [BUS_W-1:0]    keptBase;
  logic [BUS_W-1:0]    dirAddrWide;
  logic [NARROW_W-1:0] dirAddrNarrow;
  logic [BUS_W-1:0]    dirAddr;

  assign topBit = TOP_W'(VA_TOP) + TOP_W'(mawaQ);

  always_comb begin
    keptBase = '0;
    for (int i = DIR_LSB; i < BUS_W; i++)
      if (TOP_W'(i) <= topBit) keptBase[i] = baseQ[i];
  end

  assign dirAddrWide   = (keptBase >> (DIR_LSB - 3)) + {cfgQ, {PAGE_LSB{1'b0}}};
  assign dirAddrNarrow = {{(PAGE_LSB-2){1'b0}}, baseQ[NARROW_W-1:PAGE_LSB], 2'b00}
                       + {cfgQ[NARROW_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign dirAddr = wideQ ? dirAddrWide : {{(BUS_W-NARROW_W){1'b0}}, dirAddrNarrow};

  // Table-entry address and word offsets
  logic [BUS_W-1:0]    tblWide, wordWide;
  logic [NARROW_W-1:0] tblNarrow, wordNarrow;

  assign tblWide    = {{(BUS_W-22){1'b0}}, baseQ[DIR_LSB-1:3], 5'h00}
                    + {dirQ[BUS_W-1:3], 3'b000};
  assign tblNarrow  = {{(NARROW_W-14){1'b0}}, baseQ[PAGE_LSB-1:2], 4'h0}
                    + {dirQ[NARROW_W-1:2], 2'b00};
  assign wordWide   = tblWide + {{(BUS_W-SEL_W-3){1'b0}}, strobes.wordSel, 3'b000};
  assign wordNarrow = tblNarrow + {{(NARROW_W-SEL_W-2){1'b0}}, strobes.wordSel, 2'b00};

  logic [BUS_W-1:0] wordData;
  always_comb begin
    unique case (strobes.wordSel)
      SEL_W'(1): wordData = highQ;
      SEL_W'(2): wordData = ptrQ;
      default:   wordData = lowQ;
    endcase
  end

  always_comb begin
    if (strobes.rdPhase)  memAddr = dirAddr;
    else if (wideQ)       memAddr = wordWide;
    else                  memAddr = {{(BUS_W-NARROW_W){1'b0}}, wordNarrow};
  end

  assign memWdata = wideQ ? wordData
                          : {{(BUS_W-NARROW_W){1'b0}}, wordData[NARROW_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   statusQ <= '0;
    else if (strobes.loadStatus) statusQ <= dirAddr | BUS_W'(2);
  end
  assign statusOut = statusQ;

  assert_status_marked_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadStatus |=> statusOut[1]);
  assert_narrow_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrPhase && !wideQ) |-> (memWdata[BUS_W-1:NARROW_W] == '0));
  assert_narrow_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.wrPhase || strobes.rdPhase) && !wideQ) |-> (memAddr[BUS_W-1:NARROW_W] == '0));
  always_comb assert_one_phase_R10: assert (!(strobes.rdPhase && strobes.wrPhase));
endmodule

// File: rtl/bts_walker.sv
module bts_walker
  import bts_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              wideIn,
  input  logic [BUS_W-1:0]  baseIn,
  input  logic [BUS_W-1:0]  ptrIn,
  input  logic [BUS_W-1:0]  lowerIn,
  input  logic [BUS_W-1:0]  upperIn,
  input  logic [BUS_W-1:0]  cfgIn,
  input  logic [PRIV_W-1:0] privIn,
  input  logic [UW_W-1:0]   userWidthIn,
  output logic              memReq,
  output logic              memWe,
  output logic [BUS_W-1:0]  memAddr,
  output logic [BUS_W-1:0]  memWdata,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [BUS_W-1:0]  memRdata,
  output logic              busyOut,
  output logic              doneOut,
  output logic              faultOut,
  output logic [BUS_W-1:0]  statusOut
);
  walkStrobes_t strobes;
  logic         dirValidBit;

  bts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .memGnt(memGnt),
    .memRvalid(memRvalid), .dirValidBit(dirValidBit), .strobes(strobes),
    .memReq(memReq), .memWe(memWe), .busyOut(busyOut),
    .doneOut(doneOut), .faultOut(faultOut)
  );

  bts_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wideIn(wideIn),
    .baseIn(baseIn), .ptrIn(ptrIn), .lowerIn(lowerIn), .upperIn(upperIn),
    .cfgIn(cfgIn), .privIn(privIn), .userWidthIn(userWidthIn),
    .memRdata(memRdata), .dirValidBit(dirValidBit), .memAddr(memAddr),
    .memWdata(memWdata), .statusOut(statusOut)
  );

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> ($stable(memAddr) && $stable(memWe)));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> !memReq);
endmodule

// File: tb/bts_walker_bench.sv
`timescale 1ns/1ps
module bts_walker_bench;
  logic        clk = 1'b0, rstN = 1'b0, startIn = 1'b0, wideIn = 1'b0;
  logic [63:0] baseIn = '0, ptrIn = '0, lowerIn = '0, upperIn = '0, cfgIn = '0;
  logic [1:0]  privIn = '0;
  logic [4:0]  userWidthIn = '0;
  logic        memReq, memWe, memGnt = 1'b0, memRvalid = 1'b0;
  logic [63:0] memAddr, memWdata, memRdata = '0, statusOut;
  logic        busyOut, doneOut, faultOut;

  bts_walker u_bts_walker (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, grantWin = 4, readLat = 1, pend = 0;
  bit finished = 1'b0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] qAddr [$], qData [$];
  logic [63:0] expReadAddr = '0;
  string dirTag = "R2", tblTag = "R5";
  int readsSeen = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expDir(input bit wide, input logic [63:0] base,
      input logic [63:0] cfg, input logic [1:0] priv, input logic [4:0] uw);
    logic [31:0] n;
    logic [63:0] field;
    int top;
    if (!wide) begin
      n = (32'(base[31:12]) << 2) + (32'(cfg[31:12]) << 12);
      return {32'h0, n};
    end
    top = 47 + ((priv == 2'd3) ? int'(uw) : 0);
    field = '0;
    for (int i = 20; i < 64; i++) if (i <= top) field[i-17] = base[i];
    return field + {cfg[63:12], 12'h000};
  endfunction

  function automatic logic [63:0] expTbl(input bit wide, input logic [63:0] base,
      input logic [63:0] dir, input int word);
    logic [31:0] n;
    if (!wide) begin
      n = (32'(base[11:2]) << 4) + (32'(dir[31:2]) << 2) + 32'(word * 4);
      return {32'h0, n};
    end
    return (64'(base[19:3]) << 5) + (64'(dir[63:3]) << 3) + 64'(word * 8);
  endfunction

  // Memory model and scoreboard monitor, one process at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pend > 0) begin
      pend--;
      memRvalid = (pend == 0);
    end else memRvalid = 1'b0;
    if (pend > 0 && memReq) check(1'b0, "R10 request while read pending", 64'(memReq), 64'h0);
    memGnt = memReq && ((cyc % 4) < grantWin);
    if (memReq && memGnt) begin
      if (!memWe) begin
        readsSeen++;
        check(memAddr == expReadAddr, dirTag, memAddr, expReadAddr);
        memRdata = mem.exists(memAddr) ? mem[memAddr] : 64'h0;
        pend = readLat;
      end else if (qAddr.size() == 0) begin
        check(1'b0, "R4 unexpected write", memAddr, 64'h0);
      end else begin
        logic [63:0] ea, ed;
        ea = qAddr.pop_front();
        ed = qData.pop_front();
        check(memAddr == ea, {tblTag, " R7 address"}, memAddr, ea);
        check(memWdata == ed, {tblTag, " R7 data"}, memWdata, ed);
      end
    end
  end

  task automatic runStore(input bit wide, input logic [63:0] base, ptr, lo, hi, cfg,
      input logic [1:0] priv, input logic [4:0] uw, input logic [63:0] dirEntry,
      input int gw, input int lat, input bit startOnDone);
    logic [63:0] eDir, w0, w1, w2;
    bit faulty, sawDone, sawFault;
    eDir = expDir(wide, base, cfg, priv, uw);
    mem[eDir] = dirEntry;
    expReadAddr = eDir;
    dirTag = wide ? "R3" : "R2";
    tblTag = wide ? "R6" : "R5";
    faulty = (dirEntry[0] == 1'b0);
    if (!faulty) begin
      w0 = wide ? lo  : {32'h0, lo[31:0]};
      w1 = wide ? hi  : {32'h0, hi[31:0]};
      w2 = wide ? ptr : {32'h0, ptr[31:0]};
      for (int k = 0; k < 3; k++) qAddr.push_back(expTbl(wide, base, dirEntry, k));
      qData.push_back(w0); qData.push_back(w1); qData.push_back(w2);
    end
    grantWin = gw; readLat = lat; readsSeen = 0;
    @(negedge clk);
    wideIn = wide; baseIn = base; ptrIn = ptr; lowerIn = lo; upperIn = hi;
    cfgIn = cfg; privIn = priv; userWidthIn = uw; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    // R9: scramble operands while busy
    wideIn = ~wide; baseIn = ~base; ptrIn = ~ptr; lowerIn = ~lo; upperIn = ~hi;
    cfgIn = ~cfg; privIn = ~priv; userWidthIn = ~uw;
    sawDone = 1'b0; sawFault = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      startIn = (n == 2);
      if (doneOut || faultOut) begin
        sawDone = doneOut; sawFault = faultOut;
        break;
      end
    end
    startIn = startOnDone;
    check(readsSeen == 1, "R10 one directory read", 64'(readsSeen), 64'd1);
    if (faulty) begin
      check(sawFault && !sawDone, "R4 fault pulse", {62'h0, sawFault, sawDone}, 64'h2);
      check(statusOut == (eDir | 64'h2), "R4 status word", statusOut, eDir | 64'h2);
    end else begin
      check(sawDone && !sawFault, "R8 done pulse", {62'h0, sawFault, sawDone}, 64'h1);
      check(qAddr.size() == 0, "R7 all three writes seen", 64'(qAddr.size()), 64'h0);
    end
    @(negedge clk);
    startIn = 1'b0;
    check(!doneOut && !faultOut && !busyOut, "R8 single pulse then idle",
          {61'h0, doneOut, faultOut, busyOut}, 64'h0);
    if (startOnDone) begin
      @(negedge clk);
      check(!busyOut && !memReq, "R9 start on done cycle dropped",
            {62'h0, busyOut, memReq}, 64'h0);
    end
    qAddr.delete(); qData.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busyOut && !memReq && !doneOut && !faultOut, "R1 idle after reset",
          {60'h0, busyOut, memReq, doneOut, faultOut}, 64'h0);
    check(statusOut == 64'h0, "R1 status zero", statusOut, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyOut && !memReq, "R1 idle after release", {62'h0, busyOut, memReq}, 64'h0);

    // Narrow mode, full grant, upper bits of operands and entry must be dropped (R2 R5 R7)
    runStore(1'b0, 64'hDEAD_BEEF_1234_5678, 64'hAAAA_0000_0000_0123, 64'h1111_2222_3333_4444,
             64'h5555_6666_7777_8888, 64'hFFFF_0000_0040_0ABC, 2'd0, 5'd0,
             64'hFFFF_FFFF_0012_3401, 4, 1, 1'b0);
    // Narrow mode with stalls and 32-bit wrap
    runStore(1'b0, 64'h0000_0000_FFFF_FFFC, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0010,
             64'h0000_0000_0000_0020, 64'h0000_0000_FFFF_F000, 2'd3, 5'd31,
             64'h0000_0000_FFFF_FFF5, 2, 3, 1'b0);
    // Wide mode, privilege below 3 ignores the user width (R3 R6)
    runStore(1'b1, 64'hFF80_1234_5678_9ABC, 64'h0123_4567_89AB_CDEF, 64'h1000_0000_0000_0000,
             64'h2000_0000_0000_0000, 64'h0000_7000_0001_2FFF, 2'd2, 5'd9,
             64'h0000_0001_0000_0009, 3, 2, 1'b0);
    // Wide mode, privilege 3 with width 9
    runStore(1'b1, 64'hFF80_1234_5678_9ABC, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_0001,
             64'h0000_0000_0000_0002, 64'h0000_7000_0001_2000, 2'd3, 5'd9,
             64'h0123_4567_89AB_CDE1, 4, 1, 1'b0);
    // Wide mode, privilege 3 with width 16 reaches bit 63; start on done cycle (R9)
    runStore(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 64'h7777_7777_7777_7777,
             64'h8888_8888_8888_8888, 64'h1234_5678_9ABC_D000, 2'd3, 5'd16,
             64'h8000_0000_0000_0FFF, 1, 4, 1'b1);
    // Invalid entries (R4)
    runStore(1'b0, 64'h0000_0000_0ABC_D123, 64'h1, 64'h2, 64'h3, 64'h0000_0000_0010_0000,
             2'd0, 5'd0, 64'h0000_0000_0000_1000, 4, 1, 1'b0);
    runStore(1'b1, 64'h0000_7FFF_FFF0_0000, 64'h1, 64'h2, 64'h3, 64'h0000_0000_0020_0000,
             2'd3, 5'd4, 64'hFFFF_FFFF_FFFF_FFFE, 2, 2, 1'b1);
    // A valid walk after a fault must still succeed
    runStore(1'b0, 64'h0000_0000_0000_0FFC, 64'h0000_0000_0000_0099, 64'h0000_0000_0000_0055,
             64'h0000_0000_0000_0066, 64'h0, 2'd1, 5'd0, 64'h0000_0000_0000_0003, 3, 1, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule